// File: doc/BRIEF.md
# Eight-Tap Moving Average Filter

This block smooths a stream of signed samples. On every clock where it is selected, it takes one new 16-bit two's complement sample. After that clock edge, its registered output holds the mean of that sample and the seven samples accepted before it. All taps carry a weight of one, so the filter has no multipliers. The arithmetic is a sum of eight values, followed by division by eight, and the division is done by dropping low bits.

The sum is formed in a 20-bit datapath. Each sample is widened by copying its sign bit, so no partial sum can overflow. The three least significant bits of the sum are then discarded, and the next sixteen bits become the output. Because the low bits are dropped, the division rounds toward negative infinity.

A select input gates the whole block. While the select is low, neither the sample history nor the output register changes. A synchronous reset clears the history and the output.

Top module: `mavg_filter`

## Requirements
- R1: While `rst` is high at a rising clock edge, every stored history sample and `dout` become zero. After reset, the first selected sample `x` therefore gives `dout = x >>> 3`.
- R2: On each rising edge where `rst` is low and `cs` is high, `din` is accepted. From that edge on, `dout` equals floor((x0 + x1 + ... + x7) / 8), where x0 is the sample just accepted and x1..x7 are the seven samples accepted before it. Positions not yet filled since reset count as zero.
- R3: Summation uses a 20-bit sign-extended datapath, so no input pattern overflows. Eight consecutive samples of 32767 give 32767, and eight consecutive samples of -32768 give -32768.
- R4: Division rounds toward negative infinity. A lone sample of -1 gives eight outputs of -1, and a lone sample of -9 gives eight outputs of -2.
- R5: A single sample of value v, preceded and followed by zeros, gives exactly eight consecutive outputs of floor(v/8) and then zero. For v = 32767 each of the eight outputs is 4095.
- R6: On a rising edge with `rst` low and `cs` low, `din` is ignored. `dout` keeps its value and the history is not shifted, so later outputs are as if those cycles never happened.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Select; high accepts a sample, low freezes all registers |
| din | input | 16 | Signed two's complement input sample |
| dout | output | 16 | Registered signed mean of the newest eight samples |

## Verification
The bench builds the filter with its default parameters: 16-bit samples, eight taps and a 20-bit accumulator. With these values, the full-scale extremes (eight copies of 32767 or of -32768, and alternating extremes) test the guard bits directly. Small negative values test the floor rounding. Runs with a randomly deasserted select show that frozen cycles leave no trace in the history. A reset in the middle of the stream shows that the history is cleared and does not merely go stale.

// File: rtl/mavg_pkg.sv
package mavg_pkg;
  // Default geometry of the filter datapath
  localparam int DEF_DATA_W = 16;
  localparam int DEF_TAPS   = 8;
  localparam int DEF_ACC_W  = 20;

  // Sign-extend a sample held in the low data_w bits of a 32-bit word
  function automatic logic [31:0] sext32(input logic [31:0] v, input int data_w);
    logic [31:0] r;
    for (int b = 0; b < 32; b++) r[b] = (b < data_w) ? v[b] : v[data_w-1];
    return r;
  endfunction
endpackage

// File: rtl/mavg_delay_line.sv
module mavg_delay_line #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 7,
  localparam int FLAT_W = DATA_W * DEPTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  output logic [FLAT_W-1:0] taps_flat
);
  logic [DATA_W-1:0] stage [DEPTH];

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst)     stage[s] <= '0;
        else if (en) stage[s] <= (s == 0) ? din : stage[(s == 0) ? 0 : s-1];
      end
      assign taps_flat[s*DATA_W +: DATA_W] = stage[s];
    end
  endgenerate
endmodule

// File: rtl/mavg_sum_tree.sv
module mavg_sum_tree #(
  parameter int DATA_W = 16,
  parameter int N      = 8,
  parameter int ACC_W  = 20
) (
  input  logic [N*DATA_W-1:0] vals,
  output logic [ACC_W-1:0]    sum
);
  logic [ACC_W-1:0] widened [N];

  generate
    for (genvar i = 0; i < N; i++) begin : g_ext
      assign widened[i] = {{(ACC_W-DATA_W){vals[i*DATA_W+DATA_W-1]}},
                           vals[i*DATA_W +: DATA_W]};
    end
  endgenerate

  always_comb begin
    sum = '0;
    for (int i = 0; i < N; i++) sum = sum + widened[i];
  end
endmodule

// File: rtl/mavg_filter.sv
module mavg_filter
  import mavg_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int TAPS   = DEF_TAPS,
  parameter int ACC_W  = DEF_ACC_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cs,
  input  logic signed [DATA_W-1:0] din,
  output logic signed [DATA_W-1:0] dout
);
  localparam int SHIFT = $clog2(TAPS);
  localparam int HIST  = TAPS - 1;

  logic [HIST*DATA_W-1:0] history;
  logic [ACC_W-1:0]       total;

  mavg_delay_line #(.DATA_W(DATA_W), .DEPTH(HIST)) u_hist (
    .clk(clk), .rst(rst), .en(cs), .din(din), .taps_flat(history)
  );

  mavg_sum_tree #(.DATA_W(DATA_W), .N(TAPS), .ACC_W(ACC_W)) u_sum (
    .vals({history, din}), .sum(total)
  );

  // Guard bits above the kept field and the dropped fraction below it
  logic unused_total_bits;
  assign unused_total_bits = ^{total[ACC_W-1:SHIFT+DATA_W], total[SHIFT-1:0]};

  always_ff @(posedge clk) begin
    if (rst)     dout <= '0;
    else if (cs) dout <= total[SHIFT +: DATA_W];
  end
endmodule

// File: rtl/mavg_filter_chk.sv
module mavg_filter_chk #(
  parameter int DATA_W = 16,
  parameter int TAPS   = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cs,
  input logic signed [DATA_W-1:0] din,
  input logic signed [DATA_W-1:0] dout
);
  localparam int RUN_W = $clog2(TAPS + 1);
  localparam int SHIFT = $clog2(TAPS);

  logic [RUN_W-1:0]         run_len;
  logic signed [DATA_W-1:0] run_val;
  logic                     fresh;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len <= '0;
      run_val <= '0;
      fresh   <= 1'b1;
    end else if (cs) begin
      fresh   <= 1'b0;
      run_val <= din;
      if (run_len != 0 && din == run_val)
        run_len <= (run_len == RUN_W'(TAPS)) ? run_len : run_len + 1'b1;
      else
        run_len <= RUN_W'(1);
    end
  end

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> dout == '0); // R1

  AST_FIRST_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    ($past(cs) && $past(fresh) && !$past(rst)) |-> dout == ($signed($past(din)) >>> SHIFT)); // R1

  AST_CONST_RUN_MEAN: assert property (@(posedge clk) disable iff (rst)
    (run_len == RUN_W'(TAPS)) |-> dout == run_val); // R3

  AST_HOLD_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    (!$past(cs) && !$past(rst)) |-> $stable(dout)); // R6
endmodule

bind mavg_filter mavg_filter_chk #(.DATA_W(DATA_W), .TAPS(TAPS)) u_chk (
  .clk(clk), .rst(rst), .cs(cs), .din(din), .dout(dout)
);

// File: tb/mavg_filter_test.sv
`timescale 1ns/1ps
module mavg_filter_test;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               cs  = 1'b0;
  logic signed [15:0] din = '0;
  logic signed [15:0] dout;

  int n_checks = 0;
  int n_fail   = 0;
  int hist[8];
  int expected = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mavg_filter uut (.clk(clk), .rst(rst), .cs(cs), .din(din), .dout(dout));

  // Behavioural model: list of the last eight accepted samples
  task automatic model_update(input bit r, input bit c, input int x);
    int s;
    if (r) begin
      foreach (hist[k]) hist[k] = 0;
      expected = 0;
    end else if (c) begin
      for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = x;
      s = 0;
      foreach (hist[k]) s += hist[k];
      expected = s >>> 3;
    end
  endtask

  task automatic step(input bit r, input bit c, input int x, input string req);
    rst = r; cs = c; din = 16'(x);
    @(posedge clk);
    @(negedge clk);
    model_update(r, c, x);
    n_checks++;
    if (int'(dout) != expected) begin
      n_fail++;
      $display("FAIL %s: dout=%0d expected=%0d", req, dout, expected);
    end
  endtask

  task automatic zeros(input int n, input string req);
    for (int i = 0; i < n; i++) step(0, 1, 0, req);
  endtask

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) step(1, 0, 1234, "R1 reset");
    step(0, 1, 8000, "R1 first sample");
    step(0, 1, -16, "R1 second sample");
    zeros(8, "R2 drain");

    step(0, 1, 32767, "R5 impulse");
    for (int i = 0; i < 7; i++) step(0, 1, 0, "R5 impulse tail");
    zeros(3, "R5 zero after eight");

    step(0, 1, -1, "R4 minus one");
    zeros(9, "R4 minus one tail");
    step(0, 1, -9, "R4 minus nine");
    zeros(9, "R4 minus nine tail");

    for (int i = 0; i < 12; i++) step(0, 1, 32767, "R3 full positive");
    for (int i = 0; i < 12; i++) step(0, 1, -32768, "R3 full negative");
    for (int i = 0; i < 16; i++) step(0, 1, (i % 2) ? 32767 : -32768, "R3 alternating");

    for (int i = 0; i < 12; i++) step(0, 1, 1000, "R2 step");
    for (int i = 0; i < 6; i++) step(0, 0, 31000 - i * 777, "R6 deselected");
    for (int i = 0; i < 10; i++) step(0, 1, -500 + i * 37, "R6 resume");

    for (int i = 0; i < 400; i++)
      step(0, ($urandom % 10) != 0, int'($signed(16'($urandom))), "R2 random");
    for (int i = 0; i < 2; i++) step(1, 1, 999, "R1 mid reset");
    step(0, 1, -24, "R1 after mid reset");
    for (int i = 0; i < 200; i++)
      step(0, ($urandom % 4) != 0, int'($signed(16'($urandom))), "R6 random select");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule